// File: doc/BRIEF.md
# Long Vector Execution Unit

This unit carries out the three-word long-vector display instruction for a vector display processor. When the sequencer pulses `start` with the address of the opcode word, the unit reads the two operand words that follow it. The first operand word holds a dotted-line flag, a beam-on flag and magnitude M. The second holds a sign for each axis, an axis-swap flag and magnitude N. The unit adds the signed magnitudes to its X/Y beam position registers. Sums wrap at the width of the position registers.

When the beam-on flag is set, the unit raises one draw request for the line rasteriser. The request carries the start point, the end point and the dotted attribute. The unit holds the request until the rasteriser accepts it. It then pulses `done` with the number of words consumed (three) and the address of the next instruction, so the sequencer can advance its program counter. While the unit is idle, the sequencer can also load the position registers directly, as its absolute-position instructions do.

Top module: `lvec_unit`

## Requirements
- R1: After reset the unit is idle (`busy`=0). `rd_req`, `draw_valid` and `done` are 0, and `pos_x`/`pos_y` are 0.
- R2: A `start` accepted while idle produces exactly two reads: first address `pc`+1, then address `pc`+2, both modulo 2^ADDR_W. Each address is held with `rd_req` high until the cycle in which `rd_valid` is 1.
- R3: With the swap flag (third word bit 12) clear, X moves by magnitude M (second word bits 11:0) and Y moves by magnitude N (third word bits 11:0). Third word bit 14 set makes the X step a subtraction. Bit 13 set makes the Y step a subtraction.
- R4: With the swap flag set, M is applied to Y and N to X. Bit 14 still governs the X direction and bit 13 the Y direction.
- R5: New positions are computed modulo 2^POS_W (2048). This holds for sums past the top, for differences below zero, and for magnitudes of 2048 or more.
- R6: When the beam-on flag (second word bit 13) is set, exactly one draw request is raised. It carries `draw_x0`/`draw_y0` = the position before the instruction, `draw_x1`/`draw_y1` = the position after it, and `draw_dotted` = second word bit 14.
- R7: When the beam-on flag is clear, no draw request is raised, but the position is still updated.
- R8: `draw_valid` stays high with an unchanged payload until `draw_ready` is 1. `done` does not pulse before the request has been accepted.
- R9: Each instruction ends with a one-cycle `done` pulse with `next_pc` = `pc`+3 modulo 2^ADDR_W and `words_used` = 3. `pos_x`/`pos_y` already show the new position in that cycle.
- R10: `start` and the position load (`ld_en`) are ignored while `busy` is 1. A load while idle sets `pos_x`/`pos_y` to `ld_x`/`ld_y` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a long-vector instruction (taken only when idle) |
| pc | input | ADDR_W | Address of the opcode word |
| busy | output | 1 | Instruction in progress |
| ld_en | input | 1 | Load the position registers (taken only when idle) |
| ld_x | input | POS_W | X value to load |
| ld_y | input | POS_W | Y value to load |
| rd_req | output | 1 | Operand read request, held until served |
| rd_addr | output | ADDR_W | Operand read address |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | WORD_W | Operand word |
| draw_valid | output | 1 | Draw request pending |
| draw_ready | input | 1 | Rasteriser accepts the request |
| draw_x0 | output | POS_W | Line start X |
| draw_y0 | output | POS_W | Line start Y |
| draw_x1 | output | POS_W | Line end X |
| draw_y1 | output | POS_W | Line end Y |
| draw_dotted | output | 1 | Dotted-line attribute |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | ADDR_W | Address after the three words |
| words_used | output | 2 | Words consumed (3) |
| pos_x | output | POS_W | Current X position |
| pos_y | output | POS_W | Current Y position |

## Verification
The bench compares every read address, draw request and completion against a model built from the operand words. It runs both swap settings with all four sign pairs. A design that tied the signs to the magnitudes instead of the axes would move the wrong axis the wrong way. It also runs sums that wrap past 2047 and below 0, a magnitude of 4095, and an opcode at the top of memory. A design that dropped the wrap or the address rollover would give a wrong end point or fetch from the wrong word.

Further cases hold the draw port back for several cycles and clear the beam-on flag. A design that let go of the request early, or raised a request with the beam off, would leave an unmatched or missing scoreboard entry. A `start` and a position load issued mid-instruction must leave no trace. A design that restarted or took the load would issue stray reads or end at the wrong position.

// File: rtl/lvec_pkg.sv
package lvec_pkg;

   typedef enum logic [2:0] {
      LV_IDLE = 3'd0,
      LV_RD_A = 3'd1,
      LV_RD_B = 3'd2,
      LV_EXEC = 3'd3,
      LV_DRAW = 3'd4,
      LV_DONE = 3'd5
   } lv_state_e;

   typedef struct packed {
      logic dotted;
      logic beam;
      logic neg_x;
      logic neg_y;
      logic swap;
   } lv_flags_t;

   localparam int unsigned LV_WORDS = 3;

endpackage

// File: rtl/lvec_decode.sv
module lvec_decode
   import lvec_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned MAG_W  = 12
) (
   input  logic [WORD_W-1:0] word_a,
   input  logic [WORD_W-1:0] word_b,
   output lv_flags_t         flags,
   output logic [MAG_W-1:0]  mag_x,
   output logic [MAG_W-1:0]  mag_y
);
   // flag bits sit directly above the magnitude field
   localparam int unsigned SWAP_BIT = MAG_W;
   localparam int unsigned LOW_FLAG = MAG_W + 1;
   localparam int unsigned HIGH_FLAG = MAG_W + 2;

   initial begin
      if (WORD_W < MAG_W + 3)
         $error("lvec_decode: WORD_W too small for flags plus magnitude");
   end

   logic [MAG_W-1:0] mag_m;
   logic [MAG_W-1:0] mag_n;

   assign mag_m = word_a[MAG_W-1:0];
   assign mag_n = word_b[MAG_W-1:0];

   always_comb begin
      flags.dotted = word_a[HIGH_FLAG];
      flags.beam   = word_a[LOW_FLAG];
      flags.neg_x  = word_b[HIGH_FLAG];
      flags.neg_y  = word_b[LOW_FLAG];
      flags.swap   = word_b[SWAP_BIT];
   end

   always_comb begin
      if (flags.swap) begin
         mag_x = mag_n;
         mag_y = mag_m;
      end else begin
         mag_x = mag_m;
         mag_y = mag_n;
      end
   end

endmodule

// File: rtl/lvec_axis.sv
module lvec_axis #(
   parameter int unsigned POS_W = 11,
   parameter int unsigned MAG_W = 12
) (
   input  logic [POS_W-1:0] cur,
   input  logic [MAG_W-1:0] mag,
   input  logic             neg,
   output logic [POS_W-1:0] nxt
);
   logic [POS_W-1:0] step;

   generate
      if (MAG_W >= POS_W) begin : g_trunc
         // high magnitude bits vanish modulo 2^POS_W
         assign step = mag[POS_W-1:0];
      end else begin : g_ext
         assign step = {{(POS_W-MAG_W){1'b0}}, mag};
      end
   endgenerate

   always_comb begin
      if (neg) nxt = cur - step;
      else     nxt = cur + step;
   end

endmodule

// File: rtl/lvec_draw_slot.sv
module lvec_draw_slot #(
   parameter int unsigned POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [POS_W-1:0] in_x0,
   input  logic [POS_W-1:0] in_y0,
   input  logic [POS_W-1:0] in_x1,
   input  logic [POS_W-1:0] in_y1,
   input  logic             in_dotted,
   output logic             valid,
   input  logic             ready,
   output logic [POS_W-1:0] x0,
   output logic [POS_W-1:0] y0,
   output logic [POS_W-1:0] x1,
   output logic [POS_W-1:0] y1,
   output logic             dotted
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         x0     <= '0;
         y0     <= '0;
         x1     <= '0;
         y1     <= '0;
         dotted <= 1'b0;
      end else if (load) begin
         valid  <= 1'b1;
         x0     <= in_x0;
         y0     <= in_y0;
         x1     <= in_x1;
         y1     <= in_y1;
         dotted <= in_dotted;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   AST_DRAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable({x0, y0, x1, y1, dotted})); // R8

endmodule

// File: rtl/lvec_unit.sv
module lvec_unit
   import lvec_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned POS_W  = 11,
   parameter int unsigned MAG_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc,
   output logic              busy,
   input  logic              ld_en,
   input  logic [POS_W-1:0]  ld_x,
   input  logic [POS_W-1:0]  ld_y,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   output logic              draw_valid,
   input  logic              draw_ready,
   output logic [POS_W-1:0]  draw_x0,
   output logic [POS_W-1:0]  draw_y0,
   output logic [POS_W-1:0]  draw_x1,
   output logic [POS_W-1:0]  draw_y1,
   output logic              draw_dotted,
   output logic              done,
   output logic [ADDR_W-1:0] next_pc,
   output logic [1:0]        words_used,
   output logic [POS_W-1:0]  pos_x,
   output logic [POS_W-1:0]  pos_y
);
   localparam int unsigned NUM_AXES = 2;
   localparam logic [ADDR_W-1:0] OFS_A   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] OFS_B   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] OFS_END = ADDR_W'(LV_WORDS);

   initial begin
      if (POS_W < 2) $error("lvec_unit: POS_W must be at least 2");
      if (ADDR_W < 2) $error("lvec_unit: ADDR_W must be at least 2");
      if (WORD_W < MAG_W + 3) $error("lvec_unit: WORD_W too narrow");
   end

   lv_state_e         state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [WORD_W-1:0] word_a_q;
   logic [WORD_W-1:0] word_b_q;
   logic [POS_W-1:0]  pos_q   [NUM_AXES];
   logic [POS_W-1:0]  pos_nxt [NUM_AXES];
   logic [MAG_W-1:0]  mag     [NUM_AXES];
   logic              neg     [NUM_AXES];
   lv_flags_t         flags;
   logic              slot_load;

   lvec_decode #(.WORD_W(WORD_W), .MAG_W(MAG_W)) u_decode (
      .word_a (word_a_q),
      .word_b (word_b_q),
      .flags  (flags),
      .mag_x  (mag[0]),
      .mag_y  (mag[1])
   );

   assign neg[0] = flags.neg_x;
   assign neg[1] = flags.neg_y;

   generate
      for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
         lvec_axis #(.POS_W(POS_W), .MAG_W(MAG_W)) u_axis (
            .cur (pos_q[a]),
            .mag (mag[a]),
            .neg (neg[a]),
            .nxt (pos_nxt[a])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pos_q[a] <= '0;
            end else if (state_q == LV_EXEC) begin
               pos_q[a] <= pos_nxt[a];
            end else if (state_q == LV_IDLE && ld_en) begin
               pos_q[a] <= (a == 0) ? ld_x : ld_y;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= LV_IDLE;
         pc_q     <= '0;
         word_a_q <= '0;
         word_b_q <= '0;
      end else begin
         unique case (state_q)
            LV_IDLE: if (start) begin
               pc_q    <= pc;
               state_q <= LV_RD_A;
            end
            LV_RD_A: if (rd_valid) begin
               word_a_q <= rd_data;
               state_q  <= LV_RD_B;
            end
            LV_RD_B: if (rd_valid) begin
               word_b_q <= rd_data;
               state_q  <= LV_EXEC;
            end
            LV_EXEC: state_q <= flags.beam ? LV_DRAW : LV_DONE;
            LV_DRAW: if (draw_ready) state_q <= LV_DONE;
            LV_DONE: state_q <= LV_IDLE;
            default: state_q <= LV_IDLE;
         endcase
      end
   end

   assign slot_load = (state_q == LV_EXEC) && flags.beam;

   lvec_draw_slot #(.POS_W(POS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (slot_load),
      .in_x0     (pos_q[0]),
      .in_y0     (pos_q[1]),
      .in_x1     (pos_nxt[0]),
      .in_y1     (pos_nxt[1]),
      .in_dotted (flags.dotted),
      .valid     (draw_valid),
      .ready     (draw_ready),
      .x0        (draw_x0),
      .y0        (draw_y0),
      .x1        (draw_x1),
      .y1        (draw_y1),
      .dotted    (draw_dotted)
   );

   assign busy       = (state_q != LV_IDLE);
   assign rd_req     = (state_q == LV_RD_A) || (state_q == LV_RD_B);
   assign rd_addr    = pc_q + ((state_q == LV_RD_B) ? OFS_B : OFS_A);
   assign done       = (state_q == LV_DONE);
   assign next_pc    = pc_q + OFS_END;
   assign words_used = 2'(LV_WORDS);
   assign pos_x      = pos_q[0];
   assign pos_y      = pos_q[1];

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DRAW_BEAM: assert property (@(posedge clk) disable iff (!rst_n)
      draw_valid |-> flags.beam); // R7

   AST_NO_DONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !draw_valid); // R8

   AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LV_RD_A || state_q == LV_DRAW) |=> $stable({pos_x, pos_y})); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !draw_valid); // R1

endmodule

// File: tb/tb_lvec_unit.sv
module tb_lvec_unit;
   localparam int WORD_W = 16;
   localparam int ADDR_W = 12;
   localparam int POS_W  = 11;
   localparam int MAG_W  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] pc = '0;
   logic busy;
   logic ld_en = 1'b0;
   logic [POS_W-1:0] ld_x = '0, ld_y = '0;
   logic rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic rd_valid = 1'b0;
   logic [WORD_W-1:0] rd_data = '0;
   logic draw_valid;
   logic draw_ready = 1'b0;
   logic [POS_W-1:0] draw_x0, draw_y0, draw_x1, draw_y1;
   logic draw_dotted;
   logic done;
   logic [ADDR_W-1:0] next_pc;
   logic [1:0] words_used;
   logic [POS_W-1:0] pos_x, pos_y;

   always #2.5 clk = ~clk;

   lvec_unit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_W(POS_W), .MAG_W(MAG_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .busy(busy),
      .ld_en(ld_en), .ld_x(ld_x), .ld_y(ld_y),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .draw_valid(draw_valid), .draw_ready(draw_ready),
      .draw_x0(draw_x0), .draw_y0(draw_y0), .draw_x1(draw_x1), .draw_y1(draw_y1),
      .draw_dotted(draw_dotted), .done(done), .next_pc(next_pc),
      .words_used(words_used), .pos_x(pos_x), .pos_y(pos_y)
   );

   typedef struct packed {
      logic [POS_W-1:0] x0, y0, x1, y1;
      logic dotted;
      int unsigned hold;
   } draw_item_t;

   typedef struct packed {
      logic [ADDR_W-1:0] npc;
      logic [POS_W-1:0] x, y;
   } done_item_t;

   logic [ADDR_W-1:0] exp_rd[$];
   draw_item_t        exp_draw[$];
   done_item_t        exp_done[$];

   logic [WORD_W-1:0] mem [logic [ADDR_W-1:0]];
   int checks = 0;
   int errors = 0;
   int rd_lat = 1;
   int ready_delay = 0;
   logic [POS_W-1:0] mx = '0, my = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [WORD_W-1:0] mk_a(bit dot, bit beam, logic [MAG_W-1:0] m);
      return {1'b0, dot, beam, 1'b0, m};
   endfunction

   function automatic logic [WORD_W-1:0] mk_b(bit nx, bit ny, bit sw, logic [MAG_W-1:0] n);
      return {1'b0, nx, ny, sw, n};
   endfunction

   function automatic logic [POS_W-1:0] step(logic [POS_W-1:0] c, logic [MAG_W-1:0] m, bit ng);
      int v;
      v = ng ? (int'(c) - int'(m)) : (int'(c) + int'(m));
      return POS_W'(v & ((1 << POS_W) - 1));
   endfunction

   // memory model: serves a held request after rd_lat idle cycles
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (rd_valid) begin
            rd_valid = 1'b0;
            cnt = 0;
         end else if (rd_req) begin
            if (cnt >= rd_lat) begin
               rd_valid = 1'b1;
               rd_data = mem.exists(rd_addr) ? mem[rd_addr] : '0;
               cnt = 0;
            end else cnt++;
         end
      end
   end

   // draw port model: accepts after ready_delay cycles of waiting
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (draw_valid && !draw_ready) begin
            if (cnt >= ready_delay) draw_ready = 1'b1;
            else cnt++;
         end else begin
            draw_ready = 1'b0;
            cnt = 0;
         end
      end
   end

   // monitor: samples 1 ns after the falling edge, pops and compares
   initial begin
      int held = 0;
      forever begin
         @(negedge clk);
         #1;
         if (!rst_n) continue;
         if (rd_req && rd_valid) begin
            if (exp_rd.size() == 0) chk(0, "R10", "unexpected read addr", rd_addr, -1);
            else begin
               logic [ADDR_W-1:0] ea;
               ea = exp_rd.pop_front();
               chk(rd_addr == ea, "R2", "read address", rd_addr, ea);
            end
         end
         if (draw_valid) held++;
         if (draw_valid && draw_ready) begin
            if (exp_draw.size() == 0) chk(0, "R7", "unexpected draw x1", draw_x1, -1);
            else begin
               draw_item_t e;
               e = exp_draw.pop_front();
               chk(draw_x0 == e.x0, "R6", "draw x0", draw_x0, e.x0);
               chk(draw_y0 == e.y0, "R6", "draw y0", draw_y0, e.y0);
               chk(draw_x1 == e.x1, "R3", "draw x1", draw_x1, e.x1);
               chk(draw_y1 == e.y1, "R4", "draw y1", draw_y1, e.y1);
               chk(draw_dotted == e.dotted, "R6", "dotted", draw_dotted, e.dotted);
               chk(held == int'(e.hold), "R8", "cycles held", held, e.hold);
            end
            held = 0;
         end
         if (done) begin
            if (exp_done.size() == 0) chk(0, "R10", "unexpected done pc", next_pc, -1);
            else begin
               done_item_t d;
               d = exp_done.pop_front();
               chk(exp_draw.size() == 0, "R8", "done before draw accepted", exp_draw.size(), 0);
               chk(next_pc == d.npc, "R9", "next_pc", next_pc, d.npc);
               chk(words_used == 2'd3, "R9", "words_used", words_used, 3);
               chk(pos_x == d.x, "R5", "pos_x", pos_x, d.x);
               chk(pos_y == d.y, "R5", "pos_y", pos_y, d.y);
            end
         end
      end
   end

   task automatic load_pos(input logic [POS_W-1:0] x, input logic [POS_W-1:0] y);
      @(negedge clk);
      ld_en = 1'b1; ld_x = x; ld_y = y;
      @(negedge clk);
      ld_en = 1'b0;
      mx = x; my = y;
      #1;
      chk(pos_x == x && pos_y == y, "R10", "idle load", {pos_x, pos_y}, {x, y});
   endtask

   // driver: places operands, pushes expectations, pulses start
   task automatic run_vec(input logic [ADDR_W-1:0] p, input logic [WORD_W-1:0] wa,
                          input logic [WORD_W-1:0] wb, input bit disturb);
      logic [MAG_W-1:0] m, n, magx, magy;
      logic [POS_W-1:0] nx, ny;
      draw_item_t di;
      done_item_t dn;
      m = wa[MAG_W-1:0];
      n = wb[MAG_W-1:0];
      magx = wb[12] ? n : m;
      magy = wb[12] ? m : n;
      nx = step(mx, magx, wb[14]);
      ny = step(my, magy, wb[13]);
      mem[ADDR_W'(p + 1)] = wa;
      mem[ADDR_W'(p + 2)] = wb;
      exp_rd.push_back(ADDR_W'(p + 1));
      exp_rd.push_back(ADDR_W'(p + 2));
      if (wa[13]) begin
         di.x0 = mx; di.y0 = my; di.x1 = nx; di.y1 = ny;
         di.dotted = wa[14];
         di.hold = ready_delay + 1;
         exp_draw.push_back(di);
      end
      dn.npc = ADDR_W'(p + 3); dn.x = nx; dn.y = ny;
      exp_done.push_back(dn);
      mx = nx; my = ny;
      while (busy) @(negedge clk);
      @(negedge clk);
      start = 1'b1; pc = p;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         @(negedge clk);
         start = 1'b1; pc = p + 12'h100;
         ld_en = 1'b1; ld_x = 11'h7FF; ld_y = 11'h7FF;
         @(negedge clk);
         start = 1'b0; ld_en = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual 100000 expected below");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk(!busy && !rd_req && !draw_valid && !done, "R1", "reset outputs",
          {busy, rd_req, draw_valid, done}, 0);
      chk(pos_x == 0 && pos_y == 0, "R1", "reset position", {pos_x, pos_y}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      load_pos(11'd500, 11'd600);
      // R3: no swap, positive, solid, beam on
      run_vec(12'h010, mk_a(0, 1, 12'd100), mk_b(0, 0, 0, 12'd50), 0);
      // R3: no swap, both negative, dotted
      run_vec(12'h020, mk_a(1, 1, 12'd30), mk_b(1, 1, 0, 12'd70), 0);
      // R4: swap, X negative only: X -= N, Y += M
      run_vec(12'h030, mk_a(0, 1, 12'd200), mk_b(1, 0, 1, 12'd9), 0);
      // R4: swap, Y negative only
      run_vec(12'h040, mk_a(1, 1, 12'd5), mk_b(0, 1, 1, 12'd300), 0);
      // R5: wrap past top and below zero
      load_pos(11'd2040, 11'd3);
      run_vec(12'h050, mk_a(0, 1, 12'd20), mk_b(0, 1, 0, 12'd10), 0);
      // R5: magnitude 4095 both ways
      run_vec(12'h060, mk_a(0, 1, 12'hFFF), mk_b(1, 0, 0, 12'hFFF), 0);
      // R7: beam off, position still moves
      run_vec(12'h070, mk_a(1, 0, 12'd44), mk_b(0, 0, 1, 12'd66), 0);
      // R2/R9: opcode near the top of memory, address rollover
      rd_lat = 3;
      run_vec(12'hFFE, mk_a(0, 1, 12'd1), mk_b(0, 0, 0, 12'd2), 0);
      rd_lat = 0;
      // R8: draw port stalls
      ready_delay = 4;
      run_vec(12'h100, mk_a(1, 1, 12'd77), mk_b(0, 1, 1, 12'd33), 0);
      ready_delay = 0;
      // R10: start and load while busy are ignored
      ready_delay = 2;
      run_vec(12'h200, mk_a(0, 1, 12'd11), mk_b(0, 0, 0, 12'd22), 1);
      ready_delay = 0;
      repeat (5) @(negedge clk);
      #1;
      chk(pos_x == mx && pos_y == my, "R10", "position after busy load",
          {pos_x, pos_y}, {mx, my});
      chk(!busy && !rd_req, "R10", "no restart after busy start", {busy, rd_req}, 0);
      chk(exp_rd.size() + exp_draw.size() + exp_done.size() == 0, "R2",
          "outstanding expectations",
          exp_rd.size() + exp_draw.size() + exp_done.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule